// File: doc/BRIEF.md
# Packed Subword SIMD Arithmetic Unit

This unit performs one arithmetic, shift or compare operation on every lane of two 64-bit operands at once. The operand pair is viewed as eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane width goes through the same datapath and the same single register stage. The unit is intended as the packed-integer execute stage of a media datapath. Typical uses are pixel blending, filtering with small constant gains and building key masks.

Each add, subtract and scaled shift-and-add takes its overflow policy from a mode input. The policy is wraparound, signed clamping or unsigned clamping. A carry never crosses from one lane into the next. The compare operations produce a lane of all ones or all zeros, so the result can serve directly as a bitwise select mask for overlaying one image on another.

The result is registered. `out_valid` marks the cycle in which it holds the outcome of the operation presented with `in_valid` one cycle earlier.

Top module: `simd_alu`

## Requirements
- R1: `lane_sel` picks the lane width: 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. Every lane is computed on its own, no carry or borrow crosses a lane boundary, and the latency is the same for all widths.
- R2: `ovf_mode` 0 (or 3) selects wraparound. Add (opcode 0), subtract (opcode 1) and both shift-and-add operations keep the low lane bits of the exact result and drop the overflow.
- R3: `ovf_mode` 1 selects signed clamping. Operands are read as two's complement, and an exact result outside the signed lane range becomes the signed maximum or minimum on the side it overflowed.
- R4: `ovf_mode` 2 selects unsigned clamping. Operands are read as unsigned, a result above the lane maximum becomes all ones, and a negative result becomes zero.
- R5: Opcode 2 (scaled add) computes a·2^k + b per lane, with k = `shamt[1:0]`: k of 1, 2 or 3 scales by 2, 4 or 8, and k of 0 scales by 1. The overflow mode is then applied.
- R6: Opcode 3 (scaled-down add) computes floor(a / 2^k) + b per lane, with k = `shamt[1:0]`. The division is arithmetic (signed) unless `ovf_mode` is 2, in which case a is unsigned. The overflow mode is then applied.
- R7: Opcode 4 returns (a + b + 1) >> 1 per lane, computed without overflow. The lanes are signed when `ovf_mode` is 1 and unsigned otherwise.
- R8: Opcode 5 shifts left with zero fill, opcode 6 shifts right with zero fill, and opcode 7 shifts right with sign fill. The amount is `shamt` modulo the lane width.
- R9: Opcode 8 (equal) and opcode 9 (signed greater-than) write all ones into a lane whose condition holds and all zeros into a lane whose condition fails.
- R10: `out_valid` equals `in_valid` of the previous cycle. `result` changes only after a cycle with `in_valid` high, and otherwise keeps its value.
- R11: While `rst_n` is low at a clock edge, `out_valid` and `result` become 0, whatever the inputs are.
- R12: Opcodes 10 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode |
| lane_sel | input | 2 | Lane width select |
| ovf_mode | input | 2 | Overflow policy |
| shamt | input | 5 | Shift amount or scale exponent |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered lane results |

## Verification
The bench targets lane boundaries with all-ones plus one patterns.

- A carry chain that leaks into the neighbouring lane would turn zeros into ones there.
- A clamp with the wrong sign handling would wrap 0x7F+1 to 0x80 instead of holding 0x7F, or would let 0x00-1 wrap to 0xFF in unsigned mode.

Scaled adds with k=3 on negative lanes catch an extension of the wrong width or signedness. Averages of 0xFF and 0x01 catch a missing carry bit or a wrong rounding direction. Shift amounts larger than the lane width catch an unmasked amount. Idle cycles and unused opcodes expose a register that loads without a valid input or returns stale data.

// File: rtl/simd_pkg.sv
// Package: shared opcode and overflow-mode encodings for the SIMD unit.
// Assumes: opcode values not listed decode to a zero result.
package simd_pkg;

    localparam int SIMD_DATA_W = 64;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_SHLADD = 4'd2,
        OP_SHRADD = 4'd3,
        OP_AVG    = 4'd4,
        OP_SHL    = 4'd5,
        OP_SHRL   = 4'd6,
        OP_SHRA   = 4'd7,
        OP_CMPEQ  = 4'd8,
        OP_CMPGT  = 4'd9
    } simd_op_e;

    typedef enum logic [1:0] {
        OV_WRAP = 2'd0,
        OV_SSAT = 2'd1,
        OV_USAT = 2'd2
    } simd_ovf_e;

endpackage

// File: rtl/simd_lane.sv
// Module: simd_lane
// One lane of width W. Computes the selected operation combinationally.
// Assumes: W is a power of two no larger than 32, so shamt masking works.
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  simd_op_e        op_i,
    input  simd_ovf_e       ovf_i,
    input  logic [4:0]      shamt_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o
);
    localparam int GUARD = 5;
    localparam int EXT   = W + GUARD;
    localparam logic signed [EXT-1:0] ONE  = EXT'(1);
    localparam logic signed [EXT-1:0] SMAX = (ONE <<< (W - 1)) - ONE;
    localparam logic signed [EXT-1:0] SMIN = -(ONE <<< (W - 1));
    localparam logic signed [EXT-1:0] UMAX = (ONE <<< W) - ONE;

    logic                   arith_uns;
    logic                   avg_sgn;
    logic [1:0]             scale_k;
    logic [4:0]             sh_amt;
    logic signed [EXT-1:0]  ea;
    logic signed [EXT-1:0]  eb;
    logic signed [EXT-1:0]  sum;
    logic [W-1:0]           sat_val;
    logic [W+1:0]           avg_sum;

    // Operand extension: zero in unsigned clamp mode, sign otherwise.
    always_comb begin
        arith_uns = (ovf_i == OV_USAT);
        avg_sgn   = (ovf_i == OV_SSAT);
        scale_k   = shamt_i[1:0];
        sh_amt    = shamt_i & 5'(W - 1);
        ea = arith_uns ? {{GUARD{1'b0}}, a_i} : {{GUARD{a_i[W-1]}}, a_i};
        eb = arith_uns ? {{GUARD{1'b0}}, b_i} : {{GUARD{b_i[W-1]}}, b_i};
    end

    // Exact wide sum for the add family, wide enough never to overflow.
    always_comb begin
        unique case (op_i)
            OP_SUB:    sum = ea - eb;
            OP_SHLADD: sum = (ea <<< scale_k) + eb;
            OP_SHRADD: sum = (ea >>> scale_k) + eb;
            default:   sum = ea + eb;
        endcase
    end

    // Overflow policy applied to the wide sum.
    always_comb begin
        unique case (ovf_i)
            OV_SSAT: begin
                if (sum > SMAX)      sat_val = SMAX[W-1:0];
                else if (sum < SMIN) sat_val = SMIN[W-1:0];
                else                 sat_val = sum[W-1:0];
            end
            OV_USAT: begin
                if (sum[EXT-1])      sat_val = '0;
                else if (sum > UMAX) sat_val = '1;
                else                 sat_val = sum[W-1:0];
            end
            default: sat_val = sum[W-1:0];
        endcase
    end

    // Rounded average with two guard bits.
    always_comb begin
        avg_sum = {{2{avg_sgn & a_i[W-1]}}, a_i}
                + {{2{avg_sgn & b_i[W-1]}}, b_i}
                + (W + 2)'(1);
    end

    // Final lane result selection.
    always_comb begin
        unique case (op_i)
            OP_ADD, OP_SUB,
            OP_SHLADD, OP_SHRADD: res_o = sat_val;
            OP_AVG:   res_o = W'(avg_sum >> 1);
            OP_SHL:   res_o = a_i << sh_amt;
            OP_SHRL:  res_o = a_i >> sh_amt;
            OP_SHRA:  res_o = W'($signed(a_i) >>> sh_amt);
            OP_CMPEQ: res_o = (a_i == b_i) ? '1 : '0;
            OP_CMPGT: res_o = ($signed(a_i) > $signed(b_i)) ? '1 : '0;
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_bank.sv
// Module: simd_lane_bank
// Splits a DATA_W word into DATA_W/W lanes and runs one simd_lane per lane.
// Assumes: DATA_W is a multiple of W.
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int W      = 8,
    parameter int DATA_W = SIMD_DATA_W
) (
    input  simd_op_e          op_i,
    input  simd_ovf_e         ovf_i,
    input  logic [4:0]        shamt_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int N_LANES = DATA_W / W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .op_i    (op_i),
            .ovf_i   (ovf_i),
            .shamt_i (shamt_i),
            .a_i     (a_i[g*W +: W]),
            .b_i     (b_i[g*W +: W]),
            .res_o   (res_o[g*W +: W])
        );
    end

endmodule

// File: rtl/simd_alu.sv
// Module: simd_alu (top)
// Packed SIMD unit: three lane banks (8/16/32), width mux, one output register.
// Assumes: synchronous active-low reset; result loads only with in_valid.
module simd_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = SIMD_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        ovf_mode,
    input  logic [4:0]        shamt,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int N_BYTES = DATA_W / 8;
    localparam int N_HALF  = DATA_W / 16;

    simd_op_e          op_e;
    simd_ovf_e         ovf_e;
    logic [DATA_W-1:0] res8;
    logic [DATA_W-1:0] res16;
    logic [DATA_W-1:0] res32;
    logic [DATA_W-1:0] res_next;

    assign op_e  = simd_op_e'(op);
    assign ovf_e = simd_ovf_e'(ovf_mode);

    simd_lane_bank #(.W(8),  .DATA_W(DATA_W)) u_bank8 (
        .op_i(op_e), .ovf_i(ovf_e), .shamt_i(shamt),
        .a_i(opa), .b_i(opb), .res_o(res8));

    simd_lane_bank #(.W(16), .DATA_W(DATA_W)) u_bank16 (
        .op_i(op_e), .ovf_i(ovf_e), .shamt_i(shamt),
        .a_i(opa), .b_i(opb), .res_o(res16));

    simd_lane_bank #(.W(32), .DATA_W(DATA_W)) u_bank32 (
        .op_i(op_e), .ovf_i(ovf_e), .shamt_i(shamt),
        .a_i(opa), .b_i(opb), .res_o(res32));

    // Lane-width select.
    always_comb begin
        unique case (lane_sel)
            2'd0:    res_next = res8;
            2'd1:    res_next = res16;
            default: res_next = res32;
        endcase
    end

    // Output register with valid qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= res_next;
        end
    end

    // R10: valid follows one cycle later; result holds when idle.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte_chk
        // R9: compare results are whole-lane masks, so each byte is 00 or FF.
        a_r9_cmp_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (op == OP_CMPEQ || op == OP_CMPGT))
            |=> (result[g*8 +: 8] == 8'h00 || result[g*8 +: 8] == 8'hFF));
        // R4: unsigned clamped byte add never drops below its first operand.
        a_r4_usat_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == OP_ADD && ovf_mode == OV_USAT && lane_sel == 2'd0)
            |=> (result[g*8 +: 8] >= $past(opa[g*8 +: 8])));
    end

    for (genvar g = 0; g < N_HALF; g++) begin : g_half_chk
        // R3: signed clamped sum of two non-negative halves stays non-negative.
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == OP_ADD && ovf_mode == OV_SSAT && lane_sel == 2'd1
             && !opa[g*16 + 15] && !opb[g*16 + 15])
            |=> !result[g*16 + 15]);
    end

endmodule

// File: tb/tb_simd_alu.sv
// Bench: behavioural per-lane model on integers, compared every clock.
module tb_simd_alu;
    import simd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [1:0]  lane_sel;
    logic [1:0]  ovf_mode;
    logic [4:0]  shamt;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_valid;
    logic [63:0] result;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic        exp_valid;
    logic [63:0] exp_res;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .lane_sel(lane_sel), .ovf_mode(ovf_mode), .shamt(shamt),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result));

    function automatic longint clampv(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(logic [3:0] o, logic [1:0] ls,
            logic [1:0] md, logic [4:0] sh, logic [63:0] a, logic [63:0] b);
        int w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        logic [63:0] m = (64'd1 << w) - 64'd1;
        logic [63:0] acc = '0;
        for (int i = 0; i < 64 / w; i++) begin
            longint ua = longint'((a >> (i*w)) & m);
            longint ub = longint'((b >> (i*w)) & m);
            longint half = longint'(1) << (w - 1);
            longint full = longint'(1) << w;
            longint sa = (ua >= half) ? ua - full : ua;
            longint sb = (ub >= half) ? ub - full : ub;
            longint x = (md == 2'd2) ? ua : sa;
            longint y = (md == 2'd2) ? ub : sb;
            int     k = int'(sh[1:0]);
            int     s = int'(sh) % w;
            longint r;
            logic   addfam = 1'b1;
            case (o)
                4'd0: r = x + y;
                4'd1: r = x - y;
                4'd2: r = x * (longint'(1) << k) + y;
                4'd3: r = (x >>> k) + y;
                default: begin r = 0; addfam = 1'b0; end
            endcase
            if (addfam) begin
                if (md == 2'd1)      r = clampv(r, -half, half - 1);
                else if (md == 2'd2) r = clampv(r, 0, full - 1);
            end else begin
                case (o)
                    4'd4: r = (md == 2'd1) ? ((sa + sb + 1) >>> 1) : ((ua + ub + 1) >> 1);
                    4'd5: r = ua << s;
                    4'd6: r = ua >> s;
                    4'd7: r = sa >>> s;
                    4'd8: r = (ua == ub) ? full - 1 : 0;
                    4'd9: r = (sa > sb) ? full - 1 : 0;
                    default: r = 0;
                endcase
            end
            acc |= (64'(r) & m) << (i*w);
        end
        return acc;
    endfunction

    function automatic string tag_of(logic [3:0] o, logic [1:0] md);
        case (o)
            4'd0, 4'd1: return (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R2";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5, 4'd6, 4'd7: return "R8";
            4'd8, 4'd9: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check_outputs();
        n_checks++;
        if (out_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL R10 out_valid actual=%b expected=%b", out_valid, exp_valid);
        end
        n_checks++;
        if (result !== exp_res) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
        end
    endtask

    // One clock: check the previous expectation, then present new inputs.
    task automatic step(logic v, logic [3:0] o, logic [1:0] ls, logic [1:0] md,
                        logic [4:0] sh, logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        check_outputs();
        in_valid = v; op = o; lane_sel = ls; ovf_mode = md; shamt = sh;
        opa = a; opb = b;
        exp_valid = v;
        if (v) begin
            exp_res = model(o, ls, md, sh, a, b);
            exp_tag = tag;
        end else begin
            exp_tag = "R10";
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; op = 4'd0; lane_sel = 2'd0;
        ovf_mode = 2'd0; shamt = 5'd0; opa = '1; opb = '1;
        exp_valid = 1'b0; exp_res = '0; exp_tag = "R11";
        repeat (3) @(negedge clk);
        // R11: reset clears outputs even with in_valid high.
        check_outputs();
        rst_n = 1'b1; in_valid = 1'b0;
        step(1, 4'd0, 2'd0, 2'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R2");
        // R1: same operands, byte lanes vs halfword lanes differ only by carries.
        step(1, 4'd0, 2'd0, 2'd0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1");
        step(1, 4'd0, 2'd1, 2'd0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1");
        step(1, 4'd1, 2'd3, 2'd0, 0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, "R1");
        step(1, 4'd0, 2'd0, 2'd1, 0, 64'h7F80_7F80_0102_7F80, 64'h01FF_7F80_0203_0101, "R3");
        step(1, 4'd1, 2'd1, 2'd1, 0, 64'h8000_7FFF_0005_8000, 64'h0001_FFFF_0007_7FFF, "R3");
        step(1, 4'd0, 2'd0, 2'd2, 0, 64'hFF10_FF00_80FF_0001, 64'h01F0_0000_80FF_0001, "R4");
        step(1, 4'd1, 2'd0, 2'd2, 0, 64'h0005_0000_1000_FF01, 64'h0106_0001_2000_0102, "R4");
        step(1, 4'd2, 2'd1, 2'd0, 5'd3, 64'hFFFF_1234_8000_0010, 64'h0001_0002_0003_0004, "R5");
        step(1, 4'd2, 2'd1, 2'd1, 5'd3, 64'hF000_1000_0FFF_FFFF, 64'h0000_0000_0001_0001, "R5");
        step(1, 4'd2, 2'd0, 2'd2, 5'd1, 64'h8070_0102_FF01_407F, 64'h0101_0101_0101_0101, "R5");
        step(1, 4'd3, 2'd0, 2'd0, 5'd2, 64'h80FF_7F10_8181_F00C, 64'h0001_0203_0405_0607, "R6");
        step(1, 4'd3, 2'd0, 2'd2, 5'd3, 64'h80FF_7F10_8181_F00C, 64'hFF01_0203_F405_0607, "R6");
        step(1, 4'd4, 2'd0, 2'd0, 0, 64'hFF00_0102_8000_FFFE, 64'h0100_0203_80FF_FFFF, "R7");
        step(1, 4'd4, 2'd0, 2'd1, 0, 64'hFF00_0102_8000_FFFE, 64'h0100_0203_80FF_FFFF, "R7");
        step(1, 4'd5, 2'd1, 2'd0, 5'd19, 64'h8001_1234_FFFF_0001, 64'h0, "R8");
        step(1, 4'd6, 2'd0, 2'd0, 5'd10, 64'h8001_1234_FFFF_0001, 64'h0, "R8");
        step(1, 4'd7, 2'd2, 2'd0, 5'd31, 64'h8000_0000_7FFF_FFFF, 64'h0, "R8");
        step(1, 4'd8, 2'd0, 2'd0, 0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R9");
        step(1, 4'd9, 2'd1, 2'd0, 0, 64'h8000_0001_7FFF_0005, 64'h7FFF_FFFF_8000_0005, "R9");
        step(1, 4'd12, 2'd0, 2'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R12");
        // R10: idle cycles with changing inputs must hold the last result.
        step(1, 4'd0, 2'd2, 2'd3, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001, "R2");
        step(0, 4'd1, 2'd0, 2'd0, 0, 64'h5555_5555_5555_5555, 64'h1, "R10");
        step(0, 4'd0, 2'd1, 2'd1, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h2, "R10");
        for (int n = 0; n < 600; n++) begin
            logic [3:0]  ro = 4'($urandom_range(0, 11));
            logic [1:0]  rm = 2'($urandom);
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            step(($urandom % 5) != 0, ro, 2'($urandom), rm, 5'($urandom), ra, rb, tag_of(ro, rm));
        end
        step(0, 4'd0, 2'd0, 2'd0, 0, 64'h0, 64'h0, "R10");
        @(negedge clk);
        check_outputs();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule